// File: doc/BRIEF.md
# Enable-Strobe Timing Bridge for Slow Display Modules

This block sits between a fast on-chip requester and a slow display module that samples its bus only while a single enable line is high. The requester presents one read or write at a time: a direction bit, a register-select bit and, for writes, a data byte. The bridge then runs the whole enable cycle on the module side. It places the lines, waits one clock, and raises enable for a fixed number of clocks. After enable falls it keeps the requester stalled until the required low gap has passed. Back-to-back commands therefore cannot break the module's timing, and software needs no delay loops.

All three timing limits are parameters given in nanoseconds, together with the clock period in picoseconds. From these the block derives clock counts by rounding up. When the enable-high count plus the enable-low count falls short of the minimum cycle time, the low count is stretched to make up the difference. Read data is taken from the module during the last high clock and handed back with a one-clock valid pulse.

Top module: `lcd_strobe_bridge`

## Requirements
- R1: Each timing limit is turned into clocks by rounding up: HIGH = ceil(EN_HIGH_NS*1000 / CLK_PERIOD_PS), and the same for LOW and CYCLE. With a 5000 ps clock, 18 ns gives 4 clocks and 12 ns gives 3 clocks.
- R2: `lcd_en_o` stays high for exactly HIGH consecutive clocks in each access.
- R3: After `lcd_en_o` falls, `busy_o` stays high for exactly GAP more clocks, with GAP = max(LOW, CYCLE - HIGH).
- R4: When HIGH + LOW < CYCLE, the low gap is extended to CYCLE - HIGH. With HIGH=4, LOW=3 and CYCLE=10, GAP is 6.
- R5: `lcd_rs_o`, `lcd_rw_o` and `lcd_wdata_o` take the request's values at acceptance. `lcd_en_o` rises exactly one clock later. The lines then stay unchanged until the next acceptance, which is at least one clock after enable falls.
- R6: `lcd_rw_o` is 1 for a read and 0 for a write, and `lcd_rs_o` copies `req_rs_i`. For a read, `lcd_rdata_i` is sampled in the last enable-high clock. It appears on `rdata_o` with `rdata_vld_o` high for exactly the one clock after enable falls. A write gives no valid pulse.
- R7: A request is accepted when `req_i` is high and `busy_o` is low at a clock edge. `busy_o` is high from the next clock. A request made while `busy_o` is high has no effect on the lines and starts no access.
- R8: `lcd_doe_o` is high from acceptance to the end of the gap of a write access, and low at all other times.
- R9: An asynchronous low level on `rst_n` at once forces `lcd_en_o`, `busy_o`, `rdata_vld_o` and `lcd_doe_o` low. Reset release takes effect two clocks later.
- R10: With `req_i` held high, the next enable rise comes exactly GAP+2 clocks after the previous fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_rs_i | input | 1 | Register-select value for the access |
| req_wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Access in progress; requests ignored |
| rdata_o | output | DATA_W | Last captured read data |
| rdata_vld_o | output | 1 | One-clock pulse when rdata_o is new |
| lcd_en_o | output | 1 | Enable strobe to the module |
| lcd_rs_o | output | 1 | Register select to the module |
| lcd_rw_o | output | 1 | Direction to the module, 1 = read |
| lcd_wdata_o | output | DATA_W | Data driven toward the module |
| lcd_doe_o | output | 1 | Output enable for the data pads |
| lcd_rdata_i | input | DATA_W | Data returned by the module |

## Verification
The assertions check on every clock that each enable pulse lasts exactly HIGH clocks. They also check that every rise after a fall is preceded by at least GAP+2 low clocks, and that the module lines are steady across each enable edge. Further per-clock checks are that enable never appears without busy, that the pad driver is off while idle, and that the read-valid pulse lasts one clock and follows an enable fall. Some properties can only be shown by the bench scenarios. These are the actual data values captured and presented, the rounding-up of the limits into clock counts, the ignored request in the middle of an access, and the immediate effect of reset during a strobe.

// File: rtl/lcd_strobe_pkg.sv
package lcd_strobe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_GAP    = 2'd3
  } seq_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
  import lcd_strobe_pkg::*;
#(
  parameter int W      = 8,
  parameter int HIGH_C = 4,
  parameter int GAP_C  = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic         tmr_done_i,
  output logic         accept_o,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o,
  output logic         tmr_dec_o,
  output logic         capture_o,
  output logic         end_o,
  output logic         en_o,
  output logic         busy_o
);

  localparam logic [W-1:0] HIGH_LD = W'(HIGH_C - 1);
  localparam logic [W-1:0] GAP_LD  = W'(GAP_C - 1);

  seq_state_e state_q, state_d;
  logic       en_q, en_d;

  always_comb begin
    state_d    = state_q;
    accept_o   = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    tmr_dec_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        state_d    = ST_STROBE;
        tmr_load_o = 1'b1;
        tmr_val_o  = HIGH_LD;
      end
      ST_STROBE: begin
        if (tmr_done_i) begin
          state_d    = ST_GAP;
          tmr_load_o = 1'b1;
          tmr_val_o  = GAP_LD;
        end else begin
          tmr_dec_o = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_done_i) state_d = ST_IDLE;
        else            tmr_dec_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    en_d = (state_d == ST_STROBE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
    end
  end

  assign capture_o = (state_q == ST_STROBE) && tmr_done_i;
  assign end_o     = (state_q == ST_GAP) && tmr_done_i;
  assign en_o      = en_q;
  assign busy_o    = (state_q != ST_IDLE);

endmodule

// File: rtl/lcd_line_regs.sv
module lcd_line_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              req_we_i,
  input  logic              req_rs_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              capture_i,
  input  logic              end_i,
  input  logic [DATA_W-1:0] lcd_rdata_i,
  output logic              lcd_rs_o,
  output logic              lcd_rw_o,
  output logic [DATA_W-1:0] lcd_wdata_o,
  output logic              lcd_doe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o
);

  logic              rs_q, rw_q, doe_q, doe_d, vld_q, vld_d;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              rd_en, doe_en;

  always_comb begin
    rd_en  = capture_i & rw_q;
    vld_d  = rd_en;
    doe_en = accept_i | end_i;
    doe_d  = accept_i & req_we_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 1'b0;
      rw_q <= 1'b1;
      wd_q <= '0;
    end else if (accept_i) begin
      rs_q <= req_rs_i;
      rw_q <= ~req_we_i;
      wd_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      doe_q <= 1'b0;
    else if (doe_en) doe_q <= doe_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= lcd_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign lcd_rs_o    = rs_q;
  assign lcd_rw_o    = rw_q;
  assign lcd_wdata_o = wd_q;
  assign lcd_doe_o   = doe_q;
  assign rdata_o     = rd_q;
  assign rdata_vld_o = vld_q;

endmodule

// File: rtl/lcd_strobe_bridge.sv
module lcd_strobe_bridge
  import lcd_strobe_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int EN_HIGH_NS    = 700,
  parameter int EN_LOW_NS     = 700,
  parameter int EN_CYCLE_NS   = 1500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic              req_rs_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o,
  output logic              lcd_en_o,
  output logic              lcd_rs_o,
  output logic              lcd_rw_o,
  output logic [DATA_W-1:0] lcd_wdata_o,
  output logic              lcd_doe_o,
  input  logic [DATA_W-1:0] lcd_rdata_i
);

  localparam int HIGH_C = max2(1, ceil_div(EN_HIGH_NS * 1000, CLK_PERIOD_PS));
  localparam int LOW_C  = max2(1, ceil_div(EN_LOW_NS * 1000, CLK_PERIOD_PS));
  localparam int CYC_C  = ceil_div(EN_CYCLE_NS * 1000, CLK_PERIOD_PS);
  localparam int GAP_C  = max2(LOW_C, CYC_C - HIGH_C);
  localparam int TMR_W  = $clog2(max2(HIGH_C, GAP_C) + 1);

  logic             rst_meta_n, rst_sync_n;
  logic             accept, tmr_load, tmr_dec, tmr_done, capture, acc_end;
  logic [TMR_W-1:0] tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  lcd_seq_fsm #(
    .W      (TMR_W),
    .HIGH_C (HIGH_C),
    .GAP_C  (GAP_C)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_i      (req_i),
    .tmr_done_i (tmr_done),
    .accept_o   (accept),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .tmr_dec_o  (tmr_dec),
    .capture_o  (capture),
    .end_o      (acc_end),
    .en_o       (lcd_en_o),
    .busy_o     (busy_o)
  );

  lcd_phase_timer #(
    .W (TMR_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .done_o     (tmr_done)
  );

  lcd_line_regs #(
    .DATA_W (DATA_W)
  ) u_lines (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .accept_i    (accept),
    .req_we_i    (req_we_i),
    .req_rs_i    (req_rs_i),
    .req_wdata_i (req_wdata_i),
    .capture_i   (capture),
    .end_i       (acc_end),
    .lcd_rdata_i (lcd_rdata_i),
    .lcd_rs_o    (lcd_rs_o),
    .lcd_rw_o    (lcd_rw_o),
    .lcd_wdata_o (lcd_wdata_o),
    .lcd_doe_o   (lcd_doe_o),
    .rdata_o     (rdata_o),
    .rdata_vld_o (rdata_vld_o)
  );

endmodule

// File: rtl/lcd_strobe_bridge_chk.sv
module lcd_strobe_bridge_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              busy,
  input logic              rs,
  input logic              rw,
  input logic [DATA_W-1:0] wdata,
  input logic              doe,
  input logic              vld,
  input int                high_c,
  input int                gap_c
);

  logic [31:0] hi_run, lo_run;
  logic        seen_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run    <= '0;
      lo_run    <= '0;
      seen_fall <= 1'b0;
    end else begin
      hi_run <= en ? hi_run + 32'd1 : 32'd0;
      lo_run <= en ? 32'd0 : lo_run + 32'd1;
      if (en) seen_fall <= 1'b1;
    end
  end

  a_r2_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> (hi_run == 32'(high_c)));

  // R3 / R10: low gap before any rise that follows a previous strobe
  a_r3_low_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && seen_fall) |-> (lo_run >= 32'(gap_c + 2)));

  a_r5_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> ($stable(rs) && $stable(rw) && $stable(wdata)));

  a_r5_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> ($stable(rs) && $stable(rw) && $stable(wdata)));

  a_r7_en_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> busy);

  a_r8_doe_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !doe);

  a_r6_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  a_r6_vld_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld) |-> $fell(en));

endmodule

bind lcd_strobe_bridge lcd_strobe_bridge_chk #(
  .DATA_W (DATA_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .en     (lcd_en_o),
  .busy   (busy_o),
  .rs     (lcd_rs_o),
  .rw     (lcd_rw_o),
  .wdata  (lcd_wdata_o),
  .doe    (lcd_doe_o),
  .vld    (rdata_vld_o),
  .high_c (HIGH_C),
  .gap_c  (GAP_C)
);

// File: tb/lcd_strobe_bridge_tb.sv
`timescale 1ns/1ps
module lcd_strobe_bridge_tb;

  localparam int HIGH = 4;   // ceil(18000/5000)
  localparam int GAP  = 6;   // max(ceil(12000/5000)=3, 10-4)

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_i, req_we_i, req_rs_i;
  logic [7:0] req_wdata_i, cur_rd, lcd_rdata_i;
  logic       busy_o, rdata_vld_o, lcd_en_o, lcd_rs_o, lcd_rw_o, lcd_doe_o;
  logic [7:0] rdata_o, lcd_wdata_o;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  assign lcd_rdata_i = lcd_en_o ? cur_rd : 8'hEE;

  lcd_strobe_bridge #(
    .DATA_W(8), .CLK_PERIOD_PS(5000),
    .EN_HIGH_NS(18), .EN_LOW_NS(12), .EN_CYCLE_NS(48)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_we_i(req_we_i),
    .req_rs_i(req_rs_i), .req_wdata_i(req_wdata_i), .busy_o(busy_o),
    .rdata_o(rdata_o), .rdata_vld_o(rdata_vld_o), .lcd_en_o(lcd_en_o),
    .lcd_rs_o(lcd_rs_o), .lcd_rw_o(lcd_rw_o), .lcd_wdata_o(lcd_wdata_o),
    .lcd_doe_o(lcd_doe_o), .lcd_rdata_i(lcd_rdata_i)
  );

  // {we, rs, wdata, module read data}
  localparam logic [17:0] VEC [8] = '{
    {1'b1, 1'b0, 8'h38, 8'h00},
    {1'b1, 1'b1, 8'hA5, 8'h00},
    {1'b0, 1'b0, 8'h00, 8'h80},
    {1'b0, 1'b1, 8'h00, 8'h5A},
    {1'b1, 1'b1, 8'hFF, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h01},
    {1'b1, 1'b0, 8'h01, 8'h00},
    {1'b0, 1'b0, 8'h00, 8'hC3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic we, input logic rs,
                            input logic [7:0] wd, input logic [7:0] rd);
    int n;
    while (busy_o) @(negedge clk);
    req_we_i = we; req_rs_i = rs; req_wdata_i = wd; cur_rd = rd; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(busy_o == 1'b1, "R7 busy after accept", busy_o, 1);
    chk(lcd_en_o == 1'b0, "R5 setup clock before enable", lcd_en_o, 0);
    @(negedge clk);
    chk(lcd_en_o == 1'b1, "R5 enable rises after one setup clock", lcd_en_o, 1);
    chk({lcd_rs_o, lcd_rw_o, lcd_wdata_o} == {rs, ~we, we ? wd : lcd_wdata_o},
        "R6 rs/rw/data lines", {lcd_rs_o, lcd_rw_o, lcd_wdata_o}, {rs, ~we, wd});
    chk(lcd_doe_o == we, "R8 driver enable during strobe", lcd_doe_o, we);
    n = 0;
    while (lcd_en_o && n < 100) begin n++; @(negedge clk); end
    chk(n == HIGH, "R2 enable high width", n, HIGH);
    if (!we) begin
      chk(rdata_vld_o == 1'b1, "R6 read valid pulse", rdata_vld_o, 1);
      chk(rdata_o == rd, "R6 read data", rdata_o, rd);
    end else begin
      chk(rdata_vld_o == 1'b0, "R6 no valid on write", rdata_vld_o, 0);
    end
    n = 0;
    while (busy_o && n < 100) begin n++; @(negedge clk); end
    chk(n == GAP, "R3 R4 busy low gap", n, GAP);
    chk(lcd_doe_o == 1'b0, "R8 driver off when idle", lcd_doe_o, 0);
    chk(lcd_rs_o == rs, "R5 lines held after access", lcd_rs_o, rs);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    req_i = 0; req_we_i = 0; req_rs_i = 0; req_wdata_i = 0; cur_rd = 0;
    rst_n = 1'b0;
    #1;
    chk(lcd_en_o == 0 && busy_o == 0 && rdata_vld_o == 0 && lcd_doe_o == 0,
        "R9 reset state", {lcd_en_o, busy_o, rdata_vld_o, lcd_doe_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R8: table walk
    for (int i = 0; i < 8; i++)
      run_access(VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0]);

    // R10: request held high across two accesses
    req_we_i = 1; req_rs_i = 0; req_wdata_i = 8'h11; req_i = 1;
    while (!lcd_en_o) @(negedge clk);
    while (lcd_en_o) @(negedge clk);
    n = 0;
    while (!lcd_en_o && n < 100) begin n++; @(negedge clk); end
    req_i = 0;
    chk(n == GAP + 2, "R10 back-to-back low gap", n, GAP + 2);
    while (busy_o) @(negedge clk);

    // R7: request during access ignored
    req_we_i = 1; req_rs_i = 0; req_wdata_i = 8'h3C; req_i = 1;
    @(negedge clk);
    req_i = 0;
    @(negedge clk);
    req_rs_i = 1; req_wdata_i = 8'hC3; req_i = 1;
    @(negedge clk);
    req_i = 0;
    @(negedge clk);
    chk(lcd_wdata_o == 8'h3C && lcd_rs_o == 0, "R7 lines unchanged by busy request",
        {lcd_rs_o, lcd_wdata_o}, {1'b0, 8'h3C});
    while (busy_o) @(negedge clk);
    n = 0;
    repeat (12) begin if (lcd_en_o || busy_o) n++; @(negedge clk); end
    chk(n == 0, "R7 no extra access started", n, 0);

    // R9: asynchronous reset during strobe
    req_we_i = 0; req_rs_i = 1; cur_rd = 8'h77; req_i = 1;
    @(negedge clk);
    req_i = 0;
    @(negedge clk); @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk(lcd_en_o == 0 && busy_o == 0 && rdata_vld_o == 0 && lcd_doe_o == 0,
        "R9 async reset mid strobe", {lcd_en_o, busy_o, rdata_vld_o, lcd_doe_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    req_we_i = 1; req_wdata_i = 8'h42; req_i = 1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R9 release delayed", busy_o, 0);
    @(negedge clk);
    req_i = 0;
    run_access(1'b0, 1'b0, 8'h00, 8'h9C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule